// File: doc/BRIEF.md
# Pattern-Suppressing Self-Test Source

This block is a pseudo-random stimulus source for logic self-test. It steps a 16-bit shift-register generator once per clock for a session of programmable length. It also drives the inputs of the logic under test through a hold register. A small programmable table names stretches of the generator's sequence that are known to detect nothing. Each stretch is given by its opening vector and its closing vector.

When the generator reaches an opening vector, a single state flop enters the suppressed state. That vector, and every vector after it up to and including a closing vector, is kept away from the logic under test. During this time the hold register keeps the last applied vector, so the inputs of the logic under test do not switch. The generator never pauses, so the vectors after the stretch are the same as in an unfiltered run. Two counters report how many vectors were applied and how many were suppressed in the session.

Top module: `bist_vector_filter`

## Requirements
- R1: After reset, `cut_in`, both counters, `busy`, `done` and `inhibit` are all zero.
- R2: A `start` pulse loads the generator with `seed`. If `seed` is zero, it loads 16'hACE1 instead. Each session cycle, the generator moves from v to {v[14:0], v[15]^v[14]^v[12]^v[3]}.
- R3: `cfg_we` writes entry `cfg_idx` with `cfg_first`, `cfg_last` and `cfg_valid`. An entry whose valid bit is 0 never matches.
- R4: When a vector is not suppressed, `cut_in` shows that vector from the edge that processes it, and `applied_cnt` increments.
- R5: When a vector equals the opening vector of a valid entry, that vector is suppressed and `inhibit` goes to 1.
- R6: While `inhibit` is 1, a vector equal to the closing vector of any valid entry is suppressed, `inhibit` returns to 0, and the next vector is applied if it opens no stretch.
- R7: An entry whose opening and closing vectors are equal suppresses only that one vector, and `inhibit` stays 0.
- R8: While vectors are suppressed, `cut_in` holds its last value and `filtered_cnt` increments once per vector.
- R9: A session with `sess_len` = N processes exactly N vectors, one per cycle. `applied_cnt` + `filtered_cnt` then equals N, `busy` falls, and `done` rises. Outside a session, the counters and `cut_in` do not change.
- R10: `start` has no effect while `busy` is 1. A start with `sess_len` = 0 sets `done` at once and processes no vector.
- R11: A closing vector seen while `inhibit` is 0 has no effect, and that vector is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 2 | Table entry to write |
| cfg_valid | input | 1 | Valid bit for the written entry |
| cfg_first | input | 16 | Opening vector of the stretch |
| cfg_last | input | 16 | Closing vector of the stretch |
| start | input | 1 | Begins a session when idle |
| seed | input | 16 | Generator seed |
| sess_len | input | 16 | Number of vectors in the session |
| cut_in | output | 16 | Held inputs to the logic under test |
| inhibit | output | 1 | Suppression state flop |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished |
| applied_cnt | output | 16 | Vectors applied this session |
| filtered_cnt | output | 16 | Vectors suppressed this session |

## Verification
Some rules are checked by the assertions on every cycle:
- the held inputs change only when the applied count steps;
- each session cycle adds exactly one to the two counters together;
- everything stays quiet when idle;
- `busy` and `done` are never both set;
- the generator never reaches zero.

Whether a given vector should be applied or suppressed depends on the table contents and on where each stretch falls in the sequence. Only the bench scenarios can show this. They compare every cycle against a bench model of the generator and the state flop. The scenarios cover:
- single-vector stretches;
- closing vectors met while the flop is clear;
- invalid entries;
- zero seeds;
- start pulses during a session.

// File: rtl/bist_vector_filter.sv
module bist_vector_filter #(
  parameter int W = 16,
  parameter int PAIRS = 4,
  parameter int CNT_W = 16,
  parameter logic [W-1:0] TAPS = 16'hD008,
  parameter logic [W-1:0] ALT_SEED = 16'hACE1,
  localparam int IW = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  logic             cfg_valid,
  input  logic [W-1:0]     cfg_first,
  input  logic [W-1:0]     cfg_last,
  input  logic             start,
  input  logic [W-1:0]     seed,
  input  logic [CNT_W-1:0] sess_len,
  output logic [W-1:0]     cut_in,
  output logic             inhibit,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] applied_cnt,
  output logic [CNT_W-1:0] filtered_cnt
);

  logic [W-1:0]     first_q [PAIRS];
  logic [W-1:0]     last_q  [PAIRS];
  logic [PAIRS-1:0] valid_q;
  logic [PAIRS-1:0] hit_f, hit_l;
  logic [W-1:0]     lfsr_q;
  logic [CNT_W-1:0] rem_q;

  for (genvar g = 0; g < PAIRS; g++) begin : g_match
    assign hit_f[g] = valid_q[g] && (first_q[g] == lfsr_q);
    assign hit_l[g] = valid_q[g] && (last_q[g] == lfsr_q);
  end

  wire         filtered = inhibit | (|hit_f);
  wire         inh_next = filtered & ~(|hit_l);
  wire [W-1:0] lfsr_nx  = {lfsr_q[W-2:0], ^(lfsr_q & TAPS)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < PAIRS; i++) begin
        first_q[i] <= '0;
        last_q[i]  <= '0;
      end
    end else if (cfg_we && (int'(cfg_idx) < PAIRS)) begin
      first_q[cfg_idx] <= cfg_first;
      last_q[cfg_idx]  <= cfg_last;
      valid_q[cfg_idx] <= cfg_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q       <= ALT_SEED;
      cut_in       <= '0;
      inhibit      <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      applied_cnt  <= '0;
      filtered_cnt <= '0;
      rem_q        <= '0;
    end else if (start && !busy) begin
      lfsr_q       <= (seed == '0) ? ALT_SEED : seed;
      inhibit      <= 1'b0;
      applied_cnt  <= '0;
      filtered_cnt <= '0;
      rem_q        <= sess_len;
      busy         <= (sess_len != '0);
      done         <= (sess_len == '0);
    end else if (busy) begin
      lfsr_q  <= lfsr_nx;
      inhibit <= inh_next;
      if (filtered) begin
        filtered_cnt <= filtered_cnt + 1'b1;
      end else begin
        applied_cnt <= applied_cnt + 1'b1;
        cut_in      <= lfsr_q;
      end
      rem_q <= rem_q - 1'b1;
      if (rem_q == CNT_W'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bist_vector_filter_chk.sv
module bist_vector_filter_chk #(
  parameter int W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [W-1:0]     cut_in,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] applied_cnt,
  input logic [CNT_W-1:0] filtered_cnt,
  input logic [W-1:0]     lfsr_q
);

  wire [CNT_W:0] total = (CNT_W+1)'(applied_cnt) + (CNT_W+1)'(filtered_cnt);

  p_hold_while_filtered_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(applied_cnt) |-> $stable(cut_in));

  p_one_vector_per_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> total == $past(total) + 1'b1);

  p_quiet_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(applied_cnt) && $stable(filtered_cnt) && $stable(cut_in)));

  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_start_ignored_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> total != '0);

  p_lfsr_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

bind bist_vector_filter bist_vector_filter_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cut_in(cut_in), .busy(busy),
  .done(done), .applied_cnt(applied_cnt), .filtered_cnt(filtered_cnt),
  .lfsr_q(lfsr_q)
);

// File: tb/bist_vector_filter_tb.sv
module bist_vector_filter_tb;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        cfg_valid = 1'b0;
  logic [15:0] cfg_first = '0, cfg_last = '0;
  logic        start = 1'b0;
  logic [15:0] seed = '0;
  logic [15:0] sess_len = '0;
  logic [15:0] cut_in, applied_cnt, filtered_cnt;
  logic        inhibit, busy, done;

  always #10 clk = ~clk;

  bist_vector_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_valid(cfg_valid), .cfg_first(cfg_first), .cfg_last(cfg_last),
    .start(start), .seed(seed), .sess_len(sess_len), .cut_in(cut_in),
    .inhibit(inhibit), .busy(busy), .done(done),
    .applied_cnt(applied_cnt), .filtered_cnt(filtered_cnt)
  );

  int errs = 0;
  int checks = 0;
  logic [15:0] mf [P];
  logic [15:0] ml [P];
  logic        mv [P];
  logic [15:0] ecut = '0;
  logic [15:0] sq [64];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] nx(logic [15:0] v);
    return {v[14:0], v[15] ^ v[14] ^ v[12] ^ v[3]};
  endfunction

  task automatic put_pair(int i, logic v, logic [15:0] f, logic [15:0] l);
    cfg_we = 1'b1; cfg_idx = 2'(i); cfg_valid = v; cfg_first = f; cfg_last = l;
    @(negedge clk);
    cfg_we = 1'b0;
    mf[i] = f; ml[i] = l; mv[i] = v;
  endtask

  task automatic run(logic [15:0] sd, int len, int poke_at);
    logic [15:0] v;
    logic inh;
    int na, nf;
    v = (sd == 16'h0) ? 16'hACE1 : sd;
    inh = 1'b0; na = 0; nf = 0;
    seed = sd; sess_len = 16'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (len == 0) begin
      chk("R10 zero length done", done, 1);
      chk("R10 zero length busy", busy, 0);
      chk("R10 zero length counts", {applied_cnt, filtered_cnt}, 0);
      return;
    end
    chk("R9 busy after start", busy, 1);
    for (int i = 0; i < len; i++) begin
      logic hf, hl, hx, filt;
      string r;
      hf = 1'b0; hl = 1'b0; hx = 1'b0;
      for (int k = 0; k < P; k++) begin
        if (mv[k] && mf[k] == v) hf = 1'b1;
        if (mv[k] && ml[k] == v) hl = 1'b1;
        if (!mv[k] && (mf[k] == v || ml[k] == v)) hx = 1'b1;
      end
      filt = inh | hf;
      if (hx)                      r = "R3";
      else if (filt && hf && hl && !inh) r = "R7";
      else if (filt && hl)         r = "R6";
      else if (filt && inh)        r = "R8";
      else if (filt)               r = "R5";
      else if (hl)                 r = "R11";
      else                         r = "R4";
      if (i == poke_at) begin
        start = 1'b1; seed = 16'h5555; sess_len = 16'd3;
      end
      @(negedge clk);
      start = 1'b0;
      if (!filt) begin ecut = v; na++; end
      else nf++;
      inh = filt & ~hl;
      v = nx(v);
      chk({r, " cut_in"}, cut_in, ecut);
      chk({r, " inhibit"}, inhibit, inh);
    end
    chk("R9 applied count", applied_cnt, na);
    chk("R9 filtered count", filtered_cnt, nf);
    chk("R9 busy falls", busy, 0);
    chk("R9 done rises", done, 1);
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < P; k++) begin mf[k] = '0; ml[k] = '0; mv[k] = 1'b0; end
    sq[0] = 16'h1234;
    for (int i = 1; i < 64; i++) sq[i] = nx(sq[i-1]);
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 cut_in", cut_in, 0);
    chk("R1 counters", {applied_cnt, filtered_cnt}, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 inhibit", inhibit, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 zero seed substitute, no table entries
    run(16'h0, 1, -1);
    chk("R2 zero seed vector", cut_in, 16'hACE1);

    put_pair(0, 1'b1, sq[5], sq[9]);     // R5 R6 R8
    put_pair(1, 1'b1, sq[20], sq[20]);   // R7
    put_pair(2, 1'b1, sq[62], sq[50]);   // R11
    put_pair(3, 1'b0, sq[30], sq[31]);   // R3 invalid entry
    run(16'h1234, 64, 40);               // R10 start pulse mid-session
    chk("R9 split 64", applied_cnt + filtered_cnt, 64);

    // quiet while idle
    repeat (3) @(negedge clk);
    chk("R9 idle cut_in", cut_in, ecut);

    run(16'h0, 20, 7);
    run(16'h1234, 0, -1);                // R10 zero length
    chk("R10 hold after zero length", cut_in, ecut);

    // R3 enable the former invalid entry and rerun
    put_pair(3, 1'b1, sq[30], sq[31]);
    run(16'h1234, 40, -1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule